// File: doc/BRIEF.md
# Tap-Selectable Input Delay Pipeline

This block delays one 12-bit two's-complement data stream by a number of clocks chosen at run time. Words are pushed into a 16-deep register stack, and a 4-bit tap select picks which stage drives the output. A select of zero gives the shortest delay, one clock. The largest select gives sixteen clocks.

An active-low advance input gates the stack. While it is low, each rising clock edge pushes the input word into the top stage and moves every stored word one stage deeper. While it is high, the stack holds and the word at the input is lost. The tap select is registered on every edge, whatever the advance input does. A frozen stack can therefore be read out as a small addressed storage bank, which is how filter coefficients and data histories are held in front of a multiplier. Four copies of this block sit in front of a pair of multipliers.

The stack contents have no defined value after power-up unless the variant parameter asks for them to be cleared by reset. The user loads the stack before relying on it.

Top module: `tap_delay_line`

## Requirements
- R1: With the advance input low and the tap select held at value s, the output equals the input word presented s+1 clocks earlier. Select 0 gives one clock of delay and select 15 gives sixteen.
- R2: On each rising edge with `adv_ni` low, `data_i` enters stage 0 and the word in stage k moves to stage k+1. The word in the last stage is dropped.
- R3: On a rising edge with `adv_ni` high, no stage changes. The word on `data_i` at that edge is discarded and never appears at the output.
- R4: `sel_i` is registered on every rising edge whether or not the stack advances. After the edge, the output shows the stage addressed by that select. Changing the select while the stack is frozen reads out any stored word.
- R5: Words pass through bit-exact, including the two's-complement extremes 0x800 and 0x7FF.
- R6: While `rst_ni` is low, the registered select is cleared to 0, so the output shows stage 0. When `RST_STAGES` is 1, every stage is also cleared to 0 and the output reads 0 after reset. When `RST_STAGES` is 0 (the default), the stages are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_ni | input | 1 | Active-low stack advance |
| data_i | input | DATA_W (12) | Input data word, two's complement |
| sel_i | input | $clog2(DEPTH) (4) | Tap select; the delay is select+1 clocks |
| data_o | output | DATA_W (12) | Word from the selected stage |

## Verification
The bench builds the block with the default width of 12 and depth of 16, and sets `RST_STAGES` to 1. With that setting the stack has a known value right after reset, so the reset output can be checked at once and the bench's reference queue matches the hardware from the first cycle, before any words are loaded. Directed phases sweep every select value over a freshly loaded stack. They also read out a frozen stack while dropped input words sit on the port, and push the two's-complement extremes through the stack. A long random phase then toggles the advance input and the select on every cycle, so every stage is read both while the stack shifts and while it holds.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned TDL_DATA_W = 12;
  localparam int unsigned TDL_DEPTH  = 16;

  // select value s gives s+1 clocks of delay
  function automatic int unsigned tdl_delay(input int unsigned sel);
    return sel + 1;
  endfunction
endpackage

// File: rtl/tdl_stack.sv
module tdl_stack #(
  parameter int unsigned DATA_W     = tdl_pkg::TDL_DATA_W,
  parameter int unsigned DEPTH      = tdl_pkg::TDL_DEPTH,
  parameter bit          RST_STAGES = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          adv_ni,
  input  logic [DATA_W-1:0]             data_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  stk_o
);
  logic [DEPTH-1:0][DATA_W-1:0] nxt;

  always_comb begin
    nxt[0] = data_i;
    for (int i = 1; i < DEPTH; i++) nxt[i] = stk_o[i-1];
  end

  generate
    if (RST_STAGES) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stk_o <= '0;
        else if (!adv_ni) stk_o <= nxt;
      end
    end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst_ni;
      // contents undefined until loaded
      always_ff @(posedge clk_i) begin
        if (!adv_ni) stk_o <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
  parameter int unsigned DATA_W = tdl_pkg::TDL_DATA_W,
  parameter int unsigned DEPTH  = tdl_pkg::TDL_DEPTH,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] stk_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [DATA_W-1:0]            data_o
);
  assign data_o = stk_i[sel_i];
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int unsigned DATA_W     = tdl_pkg::TDL_DATA_W,
  parameter int unsigned DEPTH      = tdl_pkg::TDL_DEPTH,
  parameter bit          RST_STAGES = 1'b0,
  localparam int unsigned SEL_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DEPTH-1:0][DATA_W-1:0] stk_q;
  logic [SEL_W-1:0]             sel_q;

  // select is sampled every edge, independent of advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  tdl_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RST_STAGES(RST_STAGES)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_ni(adv_ni),
    .data_i(data_i),
    .stk_o (stk_q)
  );

  tdl_tap_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mux (
    .stk_i (stk_q),
    .sel_i (sel_q),
    .data_o(data_o)
  );
endmodule

// File: rtl/tap_delay_line_chk.sv
module tap_delay_line_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         adv_ni,
  input logic [DATA_W-1:0]            data_i,
  input logic [SEL_W-1:0]             sel_i,
  input logic [SEL_W-1:0]             sel_q,
  input logic [DEPTH-1:0][DATA_W-1:0] stk_q,
  input logic [DATA_W-1:0]            data_o
);
  assert_min_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_ni && sel_i == '0) |=> data_o == $past(data_i));

  assert_push_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_ni |=> stk_q[0] == $past(data_i));

  for (genvar i = 1; i < DEPTH; i++) begin : g_shift
    assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_ni |=> stk_q[i] == $past(stk_q[i-1]));
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_ni |=> $stable(stk_q));

  assert_sel_reg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sel_q == $past(sel_i));

  assert_sel_clear_R6: assert property (@(posedge clk_i)
    !rst_ni |-> sel_q == '0);
endmodule

bind tap_delay_line tap_delay_line_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .adv_ni(adv_ni),
  .data_i(data_i),
  .sel_i (sel_i),
  .sel_q (sel_q),
  .stk_q (stk_q),
  .data_o(data_o)
);

// File: tb/tb_tap_delay_line.sv
`timescale 1ns/1ps
module tb_tap_delay_line;
  localparam int W = 12;
  localparam int D = 16;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [S-1:0] sel = '0;
  logic [W-1:0] dout;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mdl [D];

  tap_delay_line #(.DATA_W(W), .DEPTH(D), .RST_STAGES(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_ni(adv_n),
    .data_i(din), .sel_i(sel), .data_o(dout)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] expect_tap(input logic [S-1:0] s);
    return mdl[s];
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive one cycle, update reference queue, check after the edge
  task automatic step(input logic a_n, input logic [W-1:0] d, input logic [S-1:0] s, input string tag);
    @(negedge clk);
    adv_n = a_n; din = d; sel = s;
    @(posedge clk);
    if (!a_n) begin
      for (int i = D-1; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = d;
    end
    #1;
    check(dout, expect_tap(s), tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog R2 run did not finish");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < D; i++) mdl[i] = '0;
    sel = 4'd9;
    repeat (3) @(posedge clk);
    #1;
    check(dout, '0, "R6 output during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(dout, '0, "R6 output after reset");

    // R1: load ramp, then sweep each select at fixed delay
    for (int i = 0; i < D; i++) step(1'b0, W'(12'h100 + i), 4'd0, "R1 load min delay");
    for (int s = 0; s < D; s++)
      for (int k = 0; k < 3; k++) step(1'b0, W'($urandom), S'(s), "R1 delay sweep");

    // R3: hold with junk on the input, R4: read frozen bank by address
    for (int k = 0; k < 4; k++) step(1'b1, 12'hABC, 4'd0, "R3 hold drops input");
    for (int s = 0; s < D; s++) step(1'b1, 12'h5A5, S'(s), "R4 frozen bank readout");
    step(1'b0, 12'h321, 4'd1, "R3 stale input not stored");

    // R5: extremes pass bit-exact
    step(1'b0, 12'h800, 4'd0, "R5 most negative");
    step(1'b0, 12'h7FF, 4'd0, "R5 most positive");
    step(1'b0, 12'hFFF, 4'd1, "R5 extreme one deep");
    step(1'b1, 12'h000, 4'd2, "R5 extreme two deep");

    // R2: random advance and select
    for (int n = 0; n < 2000; n++)
      step(logic'($urandom_range(0, 2) == 0), W'($urandom), S'($urandom), "R2 random shift");

    finish_run();
  end
endmodule